// File: doc/BRIEF.md
# Voted Redundancy Core with Spare Replacement

This block combines majority voting with automatic repair. A pool of module result words arrives in parallel on every valid strobe. A fixed number of core slots, three by default, each point at one module of the pool. The block votes bit by bit over the words that the slots select and registers the result. Each slot's word is then compared with the voted word. A module whose word differs from the vote is marked faulty. If a spare is left, its slot is taken over by that spare. The modules that do not start in a core slot form the spare pool, and they are used in ascending index order.

The vote in the cycle that finds a fault is still output, because the remaining majority masks the bad word. The new slot assignment is used from the next strobe on. When a fault is found and no spare is left, the block sets a sticky exhaustion flag and keeps the faulty module in the vote. When more than one slot disagrees in the same strobe, the block cannot tell which modules are at fault. In that case it swaps nothing, marks nothing, and raises a sticky multi-fault flag. With three core slots and one spare, two successive single faults are masked.

Top module: `nmr_spare_core`

## Requirements
- R1: While reset is held, and directly after it, slot k maps to module k, the faulty mask is zero, both flags are low and out_valid is low.
- R2: One cycle after a cycle with in_valid high, out_valid is high and out_word is the bitwise majority of the words of the modules mapped to the core slots. Module m's word is in_words[m*WIDTH +: WIDTH]. out_valid is low one cycle after a cycle with in_valid low.
- R3: When exactly one core slot's word differs from the vote, bit m of faulty_mask is set for that slot's module m. It is visible in the same cycle as the corresponding out_word.
- R4: On such a single fault, if a spare remains, the slot is reassigned to the lowest-index unused spare module. Slot k's module index is slot_map[k*IDX_W +: IDX_W]. The vote that found the fault still uses the old mapping.
- R5: Words of modules that are not mapped to any core slot have no effect on out_word.
- R6: On a single fault with no spare left, spares_exhausted is set and stays set until reset. The faulty module stays in its slot and is marked in faulty_mask.
- R7: With three slots and one spare, out_word stays correct through two successive single-module faults.
- R8: When two or more core slots disagree with the vote in the same strobe, slot_map and faulty_mask do not change. multi_fault is set and stays set until reset.
- R9: Cycles with in_valid low change neither slot_map nor faulty_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Module words valid this cycle |
| in_words | input | N_MOD*WIDTH | Result words of all modules, module m at bits m*WIDTH |
| out_valid | output | 1 | Voted word valid |
| out_word | output | WIDTH | Registered voted word |
| slot_map | output | N_ACT*IDX_W | Module index held by each core slot |
| faulty_mask | output | N_MOD | One bit per module marked faulty |
| spares_exhausted | output | 1 | Sticky: a fault was found with no spare left |
| multi_fault | output | 1 | Sticky: several slots disagreed at once |

## Verification
Every result is due exactly one clock edge after the strobe that caused it: the voted word, out_valid, the updated slot map, the faulty mask and both flags all come from registers loaded at that edge. The driver pushes one expected item per strobe, computed from its own model of the slots and the spare pointer. The monitor samples on the falling edge and pops an item only when out_valid is high, so each comparison lands on the cycle after its stimulus. Idle gaps are checked against the model's unchanged state before the next strobe is driven.

// File: rtl/nmr_pkg.sv
package nmr_pkg;

  // Classification of what a strobe did to the core configuration
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_SWAP    = 2'd1,
    EV_EXHAUST = 2'd2,
    EV_MULTI   = 2'd3
  } fault_event_e;

  // Number of set bits in a vector of up to 32 bits
  function automatic int unsigned popcnt32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n = n + int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/nmr_voter.sv
module nmr_voter #(
  parameter int WIDTH = 8,
  parameter int N_ACT = 3,
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MOD*WIDTH-1:0] in_words,
  input  logic [N_ACT*IDX_W-1:0] slot_map,
  output logic [WIDTH-1:0]       voted,
  output logic [N_ACT-1:0]       disagree
);

  localparam int HALF = N_ACT / 2;

  logic [WIDTH-1:0] slot_word [N_ACT];

  // Select each slot's module word
  for (genvar k = 0; k < N_ACT; k++) begin : g_slot
    logic [IDX_W-1:0] mod_idx;
    assign mod_idx      = slot_map[k*IDX_W +: IDX_W];
    assign slot_word[k] = in_words[int'(mod_idx)*WIDTH +: WIDTH];
  end

  // Bitwise majority: a bit is one when more than half the slots have it set
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < N_ACT; k++) cnt = cnt + int'(slot_word[k][b]);
      voted[b] = (cnt > HALF);
    end
  end

  // Disagreement vector: each slot compared with the vote
  for (genvar k = 0; k < N_ACT; k++) begin : g_cmp
    assign disagree[k] = (slot_word[k] != voted);
  end

endmodule

// File: rtl/nmr_fault_ctrl.sv
module nmr_fault_ctrl
  import nmr_pkg::*;
#(
  parameter int N_ACT = 3,
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [N_ACT-1:0]       disagree,
  output logic [N_ACT*IDX_W-1:0] slot_map,
  output logic [N_MOD-1:0]       faulty_mask,
  output logic                   spares_exhausted,
  output logic                   multi_fault,
  output logic                   fault_single,
  output logic                   fault_multi,
  output logic                   swap_do,
  output logic                   exhaust_hit,
  output fault_event_e           fault_event
);

  localparam int SLOT_W = (N_ACT > 1) ? $clog2(N_ACT) : 1;
  localparam int SP_W   = $clog2(N_MOD + 1);

  logic [IDX_W-1:0]  map_q [N_ACT];
  logic [SP_W-1:0]   next_spare_q;
  logic [SLOT_W-1:0] bad_slot;
  logic [IDX_W-1:0]  bad_mod;
  logic              spare_left;
  int unsigned       n_dis;

  assign n_dis = popcnt32(32'(disagree));

  // Lowest-index disagreeing slot (unique when only one disagrees)
  always_comb begin
    bad_slot = '0;
    for (int k = N_ACT - 1; k >= 0; k--) begin
      if (disagree[k]) bad_slot = SLOT_W'(k);
    end
  end

  assign bad_mod      = map_q[bad_slot];
  assign spare_left   = (next_spare_q < SP_W'(N_MOD));
  assign fault_single = in_valid && (n_dis == 1);
  assign fault_multi  = in_valid && (n_dis > 1);
  assign swap_do      = fault_single && spare_left;
  assign exhaust_hit  = fault_single && !spare_left;

  always_comb begin
    if (fault_multi)      fault_event = EV_MULTI;
    else if (swap_do)     fault_event = EV_SWAP;
    else if (exhaust_hit) fault_event = EV_EXHAUST;
    else                  fault_event = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_ACT; k++) map_q[k] <= IDX_W'(k);
      next_spare_q     <= SP_W'(N_ACT);
      faulty_mask      <= '0;
      spares_exhausted <= 1'b0;
      multi_fault      <= 1'b0;
    end else begin
      case (fault_event)
        EV_SWAP: begin
          faulty_mask[bad_mod] <= 1'b1;
          map_q[bad_slot]      <= next_spare_q[IDX_W-1:0];
          next_spare_q         <= next_spare_q + 1'b1;
        end
        EV_EXHAUST: begin
          faulty_mask[bad_mod] <= 1'b1;
          spares_exhausted     <= 1'b1;
        end
        EV_MULTI: multi_fault <= 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_ACT; k++) begin : g_pack
    assign slot_map[k*IDX_W +: IDX_W] = map_q[k];
  end

endmodule

// File: rtl/nmr_out_stage.sv
module nmr_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] voted,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= voted;
    end
  end

endmodule

// File: rtl/nmr_spare_core.sv
module nmr_spare_core
  import nmr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int N_ACT = 3,
  parameter int N_MOD = 4,
  parameter int IDX_W = $clog2(N_MOD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [N_MOD*WIDTH-1:0] in_words,
  output logic                   out_valid,
  output logic [WIDTH-1:0]       out_word,
  output logic [N_ACT*IDX_W-1:0] slot_map,
  output logic [N_MOD-1:0]       faulty_mask,
  output logic                   spares_exhausted,
  output logic                   multi_fault
);

  // Named internal events, brought out for the checker
  logic [WIDTH-1:0] voted;
  logic [N_ACT-1:0] disagree;
  logic             fault_single;
  logic             fault_multi;
  logic             swap_do;
  logic             exhaust_hit;
  fault_event_e     fault_event;

  nmr_voter #(
    .WIDTH(WIDTH), .N_ACT(N_ACT), .N_MOD(N_MOD), .IDX_W(IDX_W)
  ) u_voter (
    .in_words (in_words),
    .slot_map (slot_map),
    .voted    (voted),
    .disagree (disagree)
  );

  nmr_fault_ctrl #(
    .N_ACT(N_ACT), .N_MOD(N_MOD), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .disagree         (disagree),
    .slot_map         (slot_map),
    .faulty_mask      (faulty_mask),
    .spares_exhausted (spares_exhausted),
    .multi_fault      (multi_fault),
    .fault_single     (fault_single),
    .fault_multi      (fault_multi),
    .swap_do          (swap_do),
    .exhaust_hit      (exhaust_hit),
    .fault_event      (fault_event)
  );

  nmr_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .voted     (voted),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

endmodule

// File: rtl/nmr_spare_core_chk.sv
module nmr_spare_core_chk #(
  parameter int N_ACT = 3,
  parameter int N_MOD = 4,
  parameter int IDX_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [N_ACT*IDX_W-1:0] slot_map,
  input logic [N_MOD-1:0]       faulty_mask,
  input logic                   spares_exhausted,
  input logic                   multi_fault,
  input logic                   fault_single,
  input logic                   fault_multi,
  input logic                   swap_do,
  input logic                   exhaust_hit
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_fault_marks_module_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_single |=> (faulty_mask != '0));

  assert_swap_changes_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_do |=> !$stable(slot_map));

  assert_exhaust_keeps_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_hit |=> ($stable(slot_map) && spares_exhausted));

  assert_exhaust_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spares_exhausted |=> spares_exhausted);

  assert_multi_no_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_multi |=> ($stable(slot_map) && $stable(faulty_mask) && multi_fault));

  assert_multi_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    multi_fault |=> multi_fault);

  assert_idle_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slot_map) && $stable(faulty_mask)));

endmodule

bind nmr_spare_core nmr_spare_core_chk #(
  .N_ACT(N_ACT), .N_MOD(N_MOD), .IDX_W(IDX_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .out_valid        (out_valid),
  .slot_map         (slot_map),
  .faulty_mask      (faulty_mask),
  .spares_exhausted (spares_exhausted),
  .multi_fault      (multi_fault),
  .fault_single     (fault_single),
  .fault_multi      (fault_multi),
  .swap_do          (swap_do),
  .exhaust_hit      (exhaust_hit)
);

// File: tb/nmr_spare_core_bench.sv
module nmr_spare_core_bench;

  localparam int WIDTH = 8;
  localparam int N_ACT = 3;
  localparam int N_MOD = 4;
  localparam int IDX_W = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic [N_MOD*WIDTH-1:0] in_words = '0;
  logic                   out_valid;
  logic [WIDTH-1:0]       out_word;
  logic [N_ACT*IDX_W-1:0] slot_map;
  logic [N_MOD-1:0]       faulty_mask;
  logic                   spares_exhausted;
  logic                   multi_fault;

  always #5 clk = ~clk;

  nmr_spare_core #(.WIDTH(WIDTH), .N_ACT(N_ACT), .N_MOD(N_MOD)) u_nmr_spare_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_word(out_word), .slot_map(slot_map),
    .faulty_mask(faulty_mask), .spares_exhausted(spares_exhausted),
    .multi_fault(multi_fault)
  );

  typedef struct {
    logic [WIDTH-1:0]       word;
    logic [N_ACT*IDX_W-1:0] map;
    logic [N_MOD-1:0]       mask;
    logic                   exh;
    logic                   multi;
    string                  tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;

  // Bench model of the core configuration
  int         m_slot[N_ACT];
  int         m_next;
  logic [N_MOD-1:0] m_mask;
  logic       m_exh, m_multi;

  function automatic logic [N_ACT*IDX_W-1:0] pack_map();
    logic [N_ACT*IDX_W-1:0] v;
    for (int k = 0; k < N_ACT; k++) v[k*IDX_W +: IDX_W] = m_slot[k][IDX_W-1:0];
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N_ACT; k++) m_slot[k] = k;
    m_next = N_ACT; m_mask = '0; m_exh = 0; m_multi = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Driver: drive one strobe and push the expected result
  task automatic send(input logic [WIDTH-1:0] w0, w1, w2, w3, input string tag);
    logic [WIDTH-1:0] mw[N_MOD];
    logic [WIDTH-1:0] vote;
    int bad_cnt, bad_k;
    exp_t e;
    mw[0] = w0; mw[1] = w1; mw[2] = w2; mw[3] = w3;
    // majority: a bit wins when at least two of the three slot words have it
    vote = '0;
    for (int b = 0; b < WIDTH; b++) begin
      int ones = 0;
      for (int k = 0; k < N_ACT; k++) if (mw[m_slot[k]][b]) ones++;
      vote[b] = (2 * ones > N_ACT);
    end
    bad_cnt = 0; bad_k = 0;
    for (int k = 0; k < N_ACT; k++) if (mw[m_slot[k]] != vote) begin bad_cnt++; bad_k = k; end
    if (bad_cnt == 1) begin
      m_mask[m_slot[bad_k]] = 1'b1;
      if (m_next < N_MOD) begin m_slot[bad_k] = m_next; m_next++; end
      else m_exh = 1'b1;
    end else if (bad_cnt > 1) m_multi = 1'b1;
    e.word = vote; e.map = pack_map(); e.mask = m_mask;
    e.exh = m_exh; e.multi = m_multi; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid <= 1'b1;
    in_words <= {w3, w2, w1, w0};
    @(negedge clk);
    in_valid <= 1'b0;
  endtask

  // Monitor: compare every produced result with the queue head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " out_word"}, 32'(out_word), 32'(e.word));
        check("R4 slot_map", 32'(slot_map), 32'(e.map));
        check("R3 faulty_mask", 32'(faulty_mask), 32'(e.mask));
        check("R6 spares_exhausted", 32'(spares_exhausted), 32'(e.exh));
        check("R8 multi_fault", 32'(multi_fault), 32'(e.multi));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    check("R1 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slot_map", 32'(slot_map), 32'(pack_map()));
    check("R1 faulty_mask", 32'(faulty_mask), 0);
    check("R1 flags", {30'd0, spares_exhausted, multi_fault}, 0);
    check("R1 out_valid", 32'(out_valid), 0);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check("R2 all results seen", 32'(exp_q.size()), 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R2 and R5: spare module 3 differs but is not in the core
    send(8'h11, 8'h11, 8'h11, 8'h99, "R5");
    // R3 and R4: module 1 fails, spare 3 takes slot 1; vote is still masked
    send(8'h22, 8'h2A, 8'h22, 8'h22, "R4");
    // R5: module 1 now out of the core, its word is ignored
    send(8'h33, 8'h77, 8'h33, 8'h33, "R5");
    drain();
    // R9: idle cycles leave the configuration untouched
    repeat (3) @(negedge clk);
    check("R9 slot_map idle", 32'(slot_map), 32'(pack_map()));
    check("R9 faulty_mask idle", 32'(faulty_mask), 32'(m_mask));
    check("R2 out_valid idle", 32'(out_valid), 0);
    // R6 and R7: second fault (module 0), no spare left, still masked
    send(8'h40, 8'h44, 8'h44, 8'h44, "R7");
    send(8'h55, 8'h00, 8'h55, 8'h55, "R7");
    send(8'hA5, 8'h5A, 8'hA5, 8'hA5, "R2");
    drain();
    // R8: fresh core, all three slots disagree with the vote
    do_reset();
    send(8'h01, 8'h02, 8'h04, 8'h00, "R8");
    send(8'h66, 8'h66, 8'h66, 8'h66, "R2");
    drain();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule